// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves bytes between eight serial time-division multiplexed input lines and eight serial output lines. A frame lasts 512 clock cycles and carries 32 eight-bit channels on every line, sent most significant bit first, with each bit cell two clock cycles long. The block stores every byte it receives in a data memory indexed by line and channel. The memory is double-buffered by frame parity, so every switched byte leaves exactly one frame after it arrived.

Each output channel has an entry in a connection memory. The low byte of the entry either names a source line and channel, or is itself the byte to transmit. Two control bits in the high part of the entry select message transmission and enable the channel's driver. A global message-mode input and a global drive-enable input override the per-channel bits. Each output is a data/enable pair that stands in for a three-state pin. The connection memory is loaded through a simple write port.

Top module: `tsi_switch`

## Requirements
- R1: The frame position counts 0..511 and then wraps. Channel c, bit b (b=7 is the MSB) occupies positions 16c+2(7-b) and 16c+2(7-b)+1. Outputs change only at the start of a bit cell. The input is sampled at the edge that ends the second cycle of each cell.
- R2: When `fsync_n` is sampled low at a clock edge, the next cycle is position 0 of a new frame. Holding it low keeps the position at 0.
- R3: For a switched channel (effective message bit 0), the output byte in frame N+1 is the byte received in frame N on line low[7:5], channel low[4:0].
- R4: When high-entry bit 2 is 1, the output carries the entry's low byte, repeated every frame until rewritten.
- R5: When `msg_all` is 1, every channel behaves as if high-entry bits 2 and 0 were both 1.
- R6: When `drive_en` is 0, every `tx_oe` bit is 0 in the same cycle.
- R7: When `drive_en` is 1 and `msg_all` is 0, high-entry bit 0 alone enables a channel's driver (1 = driven).
- R8: A `tx_data` bit is 0 whenever its `tx_oe` bit is 0.
- R9: After reset every connection entry is low byte 0 with both control bits 0, so all `tx_oe` bits stay 0 until entries are written.
- R10: A write with `cm_hi_sel`=0 stores `cm_wdata` as the low byte of entry `cm_addr` = {line[2:0], channel[4:0]}. With `cm_hi_sel`=1, it stores only bits 2 and 0; all other bits are ignored. A write takes effect from the next channel boundary.
- R11: An output channel 0 sourced from input channel 31 carries the byte that finished arriving on the last edge of the previous frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, two cycles per bit cell |
| rst | input | 1 | Synchronous active-high reset |
| fsync_n | input | 1 | Active-low frame synchronisation |
| rx_data | input | 8 | Serial input, one bit per line |
| drive_en | input | 1 | Global output drive enable |
| msg_all | input | 1 | Global message mode |
| cm_we | input | 1 | Connection memory write strobe |
| cm_hi_sel | input | 1 | 1 selects the high entry bits, 0 the low byte |
| cm_addr | input | 8 | Entry address {line, channel} |
| cm_wdata | input | 8 | Write data |
| tx_data | output | 8 | Serial output data, one bit per line |
| tx_oe | output | 8 | Driver enable per output line |

## Verification
The cell-stability property assumes that `drive_en` is the only input that can change an output in mid-cell. The bench therefore moves `drive_en` only at negative clock edges and holds it steady across the edges the property samples. The frame-position properties assume `fsync_n` is a clean synchronous level. The bench drives it low for exactly one cycle: at position 511 in normal frames, and once at position 200 to force a short frame. Connection entries and `msg_all` are changed only in frames whose outputs are not compared, so every compared frame sees a stable configuration and a fully received previous frame.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int unsigned DEF_STREAMS = 8;
    localparam int unsigned DEF_CHANS   = 32;
    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned BIT_W       = $clog2(BYTE_W);
    localparam int unsigned CELL_CLKS   = 2;
    localparam int unsigned HALF_W      = $clog2(CELL_CLKS);
    localparam int unsigned HI_MSG_BIT  = 2;
    localparam int unsigned HI_OE_BIT   = 0;

    typedef logic [BYTE_W-1:0] byte_t;

    // One connection entry: per-channel control plus the low byte.
    typedef struct packed {
        logic  msg;
        logic  oe;
        byte_t low;
    } conn_t;

    // Timing events derived from the frame position.
    typedef struct packed {
        logic frame_end;
        logic sample;
        logic byte_done;
        logic fetch;
    } tick_t;

    // Global message mode forces message and enable on every channel.
    function automatic conn_t apply_global(conn_t c, logic all_msg);
        conn_t r;
        r = c;
        if (all_msg) begin
            r.msg = 1'b1;
            r.oe  = 1'b1;
        end
        return r;
    endfunction

    // Bit idx of a byte counted from the MSB.
    function automatic logic msb_first(byte_t b, logic [BIT_W-1:0] idx);
        return b[(BYTE_W-1) - int'(idx)];
    endfunction

endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer
    import tsi_pkg::*;
#(
    parameter int unsigned NUM_CHANS = DEF_CHANS,
    localparam int unsigned CHAN_W = $clog2(NUM_CHANS),
    localparam int unsigned POS_W  = CHAN_W + BIT_W + HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fsync_n,
    output logic [POS_W-1:0]  pos,
    output logic              bank,
    output logic [CHAN_W-1:0] cur_chan,
    output logic [CHAN_W-1:0] nxt_chan,
    output logic [BIT_W-1:0]  bit_idx,
    output tick_t             tk
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_CHANS * BYTE_W * CELL_CLKS - 1);

    logic [HALF_W-1:0] half;

    assign half     = pos[HALF_W-1:0];
    assign bit_idx  = pos[HALF_W +: BIT_W];
    assign cur_chan = pos[POS_W-1 -: CHAN_W];

    always_comb begin
        tk.sample    = (half == HALF_W'(CELL_CLKS - 1));
        tk.byte_done = tk.sample && (bit_idx == BIT_W'(BYTE_W - 1));
        // A sync pulse ends the frame early unless the frame has just started.
        tk.frame_end = fsync_n ? (pos == LAST_POS) : (pos != '0);
        tk.fetch     = tk.byte_done || tk.frame_end;
        nxt_chan     = tk.frame_end ? '0 : cur_chan + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos  <= '0;
            bank <= 1'b0;
        end else begin
            if (!fsync_n || pos == LAST_POS) begin
                pos <= '0;
            end else begin
                pos <= pos + 1'b1;
            end
            if (tk.frame_end) begin
                bank <= ~bank;
            end
        end
    end

endmodule

// File: rtl/tsi_rx_store.sv
module tsi_rx_store
    import tsi_pkg::*;
#(
    parameter int unsigned NUM_STREAMS = DEF_STREAMS,
    parameter int unsigned NUM_CHANS   = DEF_CHANS,
    localparam int unsigned STREAM_W = $clog2(NUM_STREAMS),
    localparam int unsigned CHAN_W   = $clog2(NUM_CHANS),
    localparam int unsigned ADDR_W   = STREAM_W + CHAN_W,
    localparam int unsigned DEPTH    = 2 * NUM_STREAMS * NUM_CHANS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_STREAMS-1:0] rx_data,
    input  logic                   sample,
    input  logic                   byte_done,
    input  logic                   wr_bank,
    input  logic [CHAN_W-1:0]      wr_chan,
    input  logic                   rd_bank,
    input  logic [ADDR_W-1:0]      rd_addr [NUM_STREAMS],
    output byte_t                  rd_byte [NUM_STREAMS]
);

    logic [BYTE_W-2:0] shreg     [NUM_STREAMS];
    byte_t             done_byte [NUM_STREAMS];
    byte_t             mem       [DEPTH];

    always_comb begin
        for (int s = 0; s < NUM_STREAMS; s++) begin
            done_byte[s] = {shreg[s], rx_data[s]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_STREAMS; s++) begin
                shreg[s] <= '0;
            end
        end else if (sample) begin
            for (int s = 0; s < NUM_STREAMS; s++) begin
                shreg[s] <= done_byte[s][BYTE_W-2:0];
            end
        end
    end

    // Completed bytes land in the bank of the frame being received.
    always_ff @(posedge clk) begin
        if (byte_done) begin
            for (int s = 0; s < NUM_STREAMS; s++) begin
                mem[{wr_bank, STREAM_W'(s), wr_chan}] <= done_byte[s];
            end
        end
    end

    // Read with forwarding of a byte that completes on this same edge.
    generate
        for (genvar o = 0; o < NUM_STREAMS; o++) begin : g_rd
            logic hit;
            assign hit = byte_done && (rd_bank == wr_bank) &&
                         (rd_addr[o][CHAN_W-1:0] == wr_chan);
            assign rd_byte[o] = hit ? done_byte[rd_addr[o][ADDR_W-1 -: STREAM_W]]
                                    : mem[{rd_bank, rd_addr[o]}];
        end
    endgenerate

endmodule

// File: rtl/tsi_conn_store.sv
module tsi_conn_store
    import tsi_pkg::*;
#(
    parameter int unsigned NUM_STREAMS = DEF_STREAMS,
    parameter int unsigned NUM_CHANS   = DEF_CHANS,
    localparam int unsigned STREAM_W = $clog2(NUM_STREAMS),
    localparam int unsigned CHAN_W   = $clog2(NUM_CHANS),
    localparam int unsigned ADDR_W   = STREAM_W + CHAN_W,
    localparam int unsigned ENTRIES  = NUM_STREAMS * NUM_CHANS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              hi_sel,
    input  logic [ADDR_W-1:0] waddr,
    input  byte_t             wdata,
    input  logic [CHAN_W-1:0] rd_chan,
    output conn_t             ent [NUM_STREAMS]
);

    conn_t mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            if (hi_sel) begin
                mem[waddr].msg <= wdata[HI_MSG_BIT];
                mem[waddr].oe  <= wdata[HI_OE_BIT];
            end else begin
                mem[waddr].low <= wdata;
            end
        end
    end

    generate
        for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_rd
            assign ent[s] = mem[{STREAM_W'(s), rd_chan}];
        end
    endgenerate

endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane
    import tsi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch,
    input  conn_t            ent,
    input  byte_t            sw_byte,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             drive_en,
    output logic             tx_bit,
    output logic             tx_en
);

    byte_t cur_byte;
    logic  cur_en;

    // The byte and enable for the coming channel are latched on its boundary.
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_byte <= '0;
            cur_en   <= 1'b0;
        end else if (fetch) begin
            cur_byte <= ent.msg ? ent.low : sw_byte;
            cur_en   <= ent.oe;
        end
    end

    assign tx_en  = drive_en & cur_en;
    assign tx_bit = tx_en & msb_first(cur_byte, bit_idx);

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int unsigned NUM_STREAMS = DEF_STREAMS,
    parameter int unsigned NUM_CHANS   = DEF_CHANS,
    localparam int unsigned STREAM_W = $clog2(NUM_STREAMS),
    localparam int unsigned CHAN_W   = $clog2(NUM_CHANS),
    localparam int unsigned ADDR_W   = STREAM_W + CHAN_W,
    localparam int unsigned POS_W    = CHAN_W + BIT_W + HALF_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   fsync_n,
    input  logic [NUM_STREAMS-1:0] rx_data,
    input  logic                   drive_en,
    input  logic                   msg_all,
    input  logic                   cm_we,
    input  logic                   cm_hi_sel,
    input  logic [ADDR_W-1:0]      cm_addr,
    input  logic [BYTE_W-1:0]      cm_wdata,
    output logic [NUM_STREAMS-1:0] tx_data,
    output logic [NUM_STREAMS-1:0] tx_oe
);

    logic [POS_W-1:0]  frame_pos;
    logic              bank;
    logic [CHAN_W-1:0] cur_chan;
    logic [CHAN_W-1:0] nxt_chan;
    logic [BIT_W-1:0]  bit_idx;
    tick_t             tk;
    logic              rd_bank;

    conn_t             conn_raw [NUM_STREAMS];
    conn_t             conn_eff [NUM_STREAMS];
    logic [ADDR_W-1:0] src_addr [NUM_STREAMS];
    byte_t             sw_byte  [NUM_STREAMS];

    tsi_frame_timer #(.NUM_CHANS(NUM_CHANS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .fsync_n  (fsync_n),
        .pos      (frame_pos),
        .bank     (bank),
        .cur_chan (cur_chan),
        .nxt_chan (nxt_chan),
        .bit_idx  (bit_idx),
        .tk       (tk)
    );

    // The fetch for channel 0 reads the bank of the frame now ending;
    // every other fetch reads the bank of the previous frame.
    assign rd_bank = tk.frame_end ? bank : ~bank;

    tsi_rx_store #(.NUM_STREAMS(NUM_STREAMS), .NUM_CHANS(NUM_CHANS)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .rx_data   (rx_data),
        .sample    (tk.sample),
        .byte_done (tk.byte_done),
        .wr_bank   (bank),
        .wr_chan   (cur_chan),
        .rd_bank   (rd_bank),
        .rd_addr   (src_addr),
        .rd_byte   (sw_byte)
    );

    tsi_conn_store #(.NUM_STREAMS(NUM_STREAMS), .NUM_CHANS(NUM_CHANS)) u_conn (
        .clk     (clk),
        .rst     (rst),
        .we      (cm_we),
        .hi_sel  (cm_hi_sel),
        .waddr   (cm_addr),
        .wdata   (cm_wdata),
        .rd_chan (nxt_chan),
        .ent     (conn_raw)
    );

    generate
        for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_lane
            assign conn_eff[s] = apply_global(conn_raw[s], msg_all);
            assign src_addr[s] = conn_raw[s].low[ADDR_W-1:0];

            tsi_tx_lane u_lane (
                .clk      (clk),
                .rst      (rst),
                .fetch    (tk.fetch),
                .ent      (conn_eff[s]),
                .sw_byte  (sw_byte[s]),
                .bit_idx  (bit_idx),
                .drive_en (drive_en),
                .tx_bit   (tx_data[s]),
                .tx_en    (tx_oe[s])
            );
        end
    endgenerate

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
    parameter int unsigned NUM_STREAMS = 8,
    parameter int unsigned POS_W       = 9,
    localparam logic [POS_W-1:0] LAST_POS = '1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   fsync_n,
    input logic                   drive_en,
    input logic [NUM_STREAMS-1:0] tx_data,
    input logic [NUM_STREAMS-1:0] tx_oe,
    input logic [POS_W-1:0]       frame_pos
);

    AST_DRIVE_OFF: assert property (@(posedge clk) disable iff (rst)
        !drive_en |-> (tx_oe == '0)); // R6

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (tx_data & ~tx_oe) == '0); // R8

    AST_CELL_STABLE: assert property (@(posedge clk) disable iff (rst)
        (frame_pos[0] && $stable(drive_en)) |-> ($stable(tx_data) && $stable(tx_oe))); // R1

    AST_FRAME_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (fsync_n && frame_pos != LAST_POS) |=> (frame_pos == POS_W'($past(frame_pos) + 1'b1))); // R1

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        (fsync_n && frame_pos == LAST_POS) |=> (frame_pos == '0)); // R1

    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (rst)
        !fsync_n |=> (frame_pos == '0)); // R2

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx_oe == '0)); // R9

endmodule

bind tsi_switch tsi_switch_chk #(
    .NUM_STREAMS (NUM_STREAMS),
    .POS_W       (POS_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .fsync_n   (fsync_n),
    .drive_en  (drive_en),
    .tx_data   (tx_data),
    .tx_oe     (tx_oe),
    .frame_pos (frame_pos)
);

// File: tb/tsi_switch_tb_top.sv
module tsi_switch_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       fsync_n;
    logic [7:0] rx_data;
    logic       drive_en;
    logic       msg_all;
    logic       cm_we;
    logic       cm_hi_sel;
    logic [7:0] cm_addr;
    logic [7:0] cm_wdata;
    logic [7:0] tx_data;
    logic [7:0] tx_oe;

    always #4 clk = ~clk;

    tsi_switch dut_i (
        .clk       (clk),
        .rst       (rst),
        .fsync_n   (fsync_n),
        .rx_data   (rx_data),
        .drive_en  (drive_en),
        .msg_all   (msg_all),
        .cm_we     (cm_we),
        .cm_hi_sel (cm_hi_sel),
        .cm_addr   (cm_addr),
        .cm_wdata  (cm_wdata),
        .tx_data   (tx_data),
        .tx_oe     (tx_oe)
    );

    int    checks = 0;
    int    errors = 0;
    int    tpos = 0;
    int    frame_idx = 0;
    bit    check_on = 0;
    bit    de_gap = 0;
    bit    force_sync = 0;
    bit    done = 0;
    string ptag = "R9";

    logic [7:0] cfg_low [8][32];
    logic       cfg_msg [8][32];
    logic       cfg_oe  [8][32];
    logic       msg_all_r = 1'b0;

    function automatic logic [7:0] gen_in(int f, int s, int c);
        return 8'((f * 67 + s * 29 + c * 11 + 5) % 256);
    endfunction

    task automatic compare_outputs(int c, int b);
        for (int s = 0; s < 8; s++) begin
            logic       e_msg;
            logic       e_en;
            logic       e_oe;
            logic       e_d;
            logic [7:0] lo;
            logic [7:0] bv;
            lo    = cfg_low[s][c];
            e_msg = msg_all_r | cfg_msg[s][c];
            e_en  = msg_all_r | cfg_oe[s][c];
            if (e_msg) bv = lo;
            else if (frame_idx > 0) bv = gen_in(frame_idx - 1, int'(lo[7:5]), int'(lo[4:0]));
            else bv = 8'h00;
            e_oe = drive_en & e_en;
            e_d  = e_oe & bv[b];
            checks++;
            if (tx_oe[s] !== e_oe || tx_data[s] !== e_d) begin
                errors++;
                $display("FAIL %s%s frame %0d pos %0d line %0d ch %0d: got oe=%b d=%b exp oe=%b d=%b",
                         ptag, (e_oe ? "" : " R8"), frame_idx, tpos, s, c,
                         tx_oe[s], tx_data[s], e_oe, e_d);
            end
        end
    endtask

    // One clock cycle: entered and left at a negative edge.
    task automatic step();
        logic [7:0] rx_v;
        logic       fs;
        int         c;
        int         b;
        c  = tpos / 16;
        b  = 7 - ((tpos % 16) / 2);
        fs = (tpos == 511) || force_sync;
        for (int s = 0; s < 8; s++) begin
            logic [7:0] v;
            v = gen_in(frame_idx, s, c);
            rx_v[s] = v[b];
        end
        rx_data  = rx_v;
        fsync_n  = ~fs;
        drive_en = !(de_gap && tpos >= 100 && tpos < 300);
        #1;
        if (check_on) compare_outputs(c, b);
        @(posedge clk);
        if (fs) begin
            if (tpos != 0) begin
                tpos = 0;
                frame_idx++;
            end
        end else if (tpos == 511) begin
            tpos = 0;
            frame_idx++;
        end else begin
            tpos++;
        end
        @(negedge clk);
    endtask

    task automatic run_frames(int n);
        repeat (n) begin
            step();
            while (tpos != 0) step();
        end
    endtask

    // R10: every entry is written through the port; high writes carry junk bits.
    task automatic load_pattern(int kind);
        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 32; c++) begin
                logic [7:0] lo;
                logic       m;
                logic       o;
                case (kind)
                    0: begin
                        lo = {3'((s * 3 + 1) % 8), 5'((31 - c + s) % 32)};
                        m  = 1'b0;
                        o  = (c != 5);
                    end
                    1: begin
                        m  = c[0];
                        lo = m ? (8'((s * 32 + c) % 256) ^ 8'h5A)
                               : {3'(7 - s), 5'((c * 7) % 32)};
                        o  = (c % 3) != 0;
                    end
                    default: begin
                        lo = 8'((s * 17 + c * 3 + 9) % 256);
                        m  = 1'b0;
                        o  = 1'b0;
                    end
                endcase
                cfg_low[s][c] = lo;
                cfg_msg[s][c] = m;
                cfg_oe[s][c]  = o;
                cm_we     = 1'b1;
                cm_hi_sel = 1'b0;
                cm_addr   = {3'(s), 5'(c)};
                cm_wdata  = lo;
                step();
                cm_hi_sel = 1'b1;
                cm_wdata  = 8'hFA & ~8'h05 | {5'b0, m, 1'b0, o};
                step();
            end
        end
        cm_we = 1'b0;
    endtask

    initial begin
        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 32; c++) begin
                cfg_low[s][c] = 8'h00;
                cfg_msg[s][c] = 1'b0;
                cfg_oe[s][c]  = 1'b0;
            end
        end
        rst = 1'b1; fsync_n = 1'b1; rx_data = 8'h00; drive_en = 1'b1;
        msg_all = 1'b0; cm_we = 1'b0; cm_hi_sel = 1'b0; cm_addr = 8'h00; cm_wdata = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        checks++;
        if (tx_oe !== 8'h00) begin // R9
            errors++;
            $display("FAIL R9 during reset: got tx_oe=%h exp 00", tx_oe);
        end
        rst = 1'b0;

        // R9 R1: reset configuration keeps every output off for a whole frame.
        ptag = "R9 R1"; check_on = 1'b1;
        run_frames(1);

        // R3 R7 R10 R11: switched pattern, line 0 channel 0 sourced from channel 31.
        check_on = 1'b0;
        load_pattern(0);
        run_frames(1);
        ptag = "R3 R7 R10 R11"; check_on = 1'b1;
        run_frames(2);

        // R4 R7: per-channel message bytes repeated over frames, with a drive gap (R6).
        check_on = 1'b0;
        load_pattern(1);
        run_frames(1);
        ptag = "R4 R7"; check_on = 1'b1;
        run_frames(1);
        ptag = "R6 R4"; de_gap = 1'b1;
        run_frames(1);
        ptag = "R4"; de_gap = 1'b0;
        run_frames(1);

        // R5: global message mode overrides cleared control bits.
        check_on = 1'b0;
        msg_all_r = 1'b1; msg_all = 1'b1;
        load_pattern(2);
        run_frames(1);
        ptag = "R5"; check_on = 1'b1;
        run_frames(2);
        ptag = "R5 R6"; de_gap = 1'b1;
        run_frames(1);
        de_gap = 1'b0;

        // R2: a sync pulse in mid-frame restarts the frame at position 0.
        check_on = 1'b0;
        msg_all_r = 1'b0; msg_all = 1'b0;
        load_pattern(0);
        run_frames(1);
        ptag = "R2 R3"; check_on = 1'b1;
        while (tpos != 200) step();
        force_sync = 1'b1;
        step();
        force_sync = 1'b0;
        check_on = 1'b0;
        run_frames(1);
        ptag = "R2 R3"; check_on = 1'b1;
        run_frames(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: got no completion after %0d cycles, exp completion", 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule